// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display. A programmed set of fields is held in the block: eight for the horizontal axis, counted in 8-pixel characters, and eight for the vertical axis, counted in lines. From these fields it runs a character counter and a line counter. It drives horizontal and vertical sync, a display-enable window and a one-cycle start-of-frame marker. One clock cycle is one character time. Pixel serialisation and sync polarity are left to the logic around it.

The fields use fixed biases. Software writes the horizontal total as the character count minus five. Both display-end fields are written as the last visible index, which is the count minus one. The vertical total is the line count minus two, and the vertical sync start is the start line minus one. The sync end fields keep only a few low bits: five bits horizontally, of the end character, and four bits vertically, of the end line minus one. The window ends at the first counter value after the start whose low bits match the field. All fields are loaded together in one parallel strobe, and that strobe restarts the raster. After reset the block runs a 640×480 mode. That mode has 16/96/48-pixel horizontal front porch, sync and back porch, and 10/2/33-line vertical ones.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset both counters are 0 and the fields hold the 640×480 mode: horizontal total field 95, display-end field 79, sync start 82, sync end field 30, vertical total field 523, display-end field 479, sync start field 489, sync end field 11.
- R2: The character counter steps by one each cycle from 0 to (horizontal total field + 4) and then returns to 0.
- R3: The line counter steps by one only on the cycle in which the character counter wraps. It runs from 0 to (vertical total field + 1) and then returns to 0.
- R4: Display enable is high exactly when the character count is at most the horizontal display-end field and the line count is at most the vertical display-end field.
- R5: Horizontal sync is high on the character equal to the sync start field. It stays high on every later character until it reaches the first character whose count bits [4:0] equal the 5-bit sync end field. That character is excluded.
- R6: Vertical sync is high for the whole line numbered (sync start field + 1). It stays high on later lines until it reaches the first line whose count bits [3:0] equal (sync end field + 1) mod 16. That line is excluded.
- R7: Start of frame is high exactly when both counters are 0.
- R8: A cycle with the load strobe high captures every field from the configuration inputs. In the next cycle both counters are 0 and both sync windows are closed, unless a start matches at count 0.
- R9: The sync end compare uses only the truncated low bits. A horizontal end field equal to the start's low five bits therefore keeps sync high for 32 characters. A vertical end that is numerically below the start line closes on the first later line whose low four bits match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load all fields and restart the raster |
| cfg_htot | input | HF_W | Horizontal total minus 5 |
| cfg_hde | input | HF_W | Horizontal display end minus 1 |
| cfg_hss | input | HF_W | Horizontal sync start character |
| cfg_hse | input | HSE_W | Low bits of horizontal sync end character |
| cfg_vtot | input | VF_W | Vertical total minus 2 |
| cfg_vde | input | VF_W | Vertical display end minus 1 |
| cfg_vss | input | VF_W | Vertical sync start line minus 1 |
| cfg_vse | input | VSE_W | Low bits of vertical sync end line minus 1 |
| h_count | output | HF_W+1 | Character counter |
| v_count | output | VF_W+1 | Line counter |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Visible area window |
| frame_start | output | 1 | High at character 0 of line 0 |

## Verification
The assertions assume that the configuration inputs matter only in a cycle where the load strobe is high. Outside that cycle the fields stay constant, so a sync window can only open at its start count and close at a truncated end match. The bench therefore changes fields only together with a single-cycle load pulse. It then runs whole frames of each mode: the reset mode, a small mode with short windows, and a mode whose end fields exercise the low-bit wrap.

// File: rtl/crt_tg_pkg.sv
package crt_tg_pkg;
   localparam int CHAR_PX    = 8;
   localparam int H_TOT_BIAS = 5;
   localparam int V_TOT_BIAS = 2;
   localparam int LAST_BIAS  = 1;

   // reset mode, pixel and line units
   localparam int M_XRES   = 640;
   localparam int M_HFRONT = 16;
   localparam int M_HPULSE = 96;
   localparam int M_HBACK  = 48;
   localparam int M_YRES   = 480;
   localparam int M_VFRONT = 10;
   localparam int M_VPULSE = 2;
   localparam int M_VBACK  = 33;

   function automatic int chars(input int px);
      return px / CHAR_PX;
   endfunction

   localparam int DEF_HTOT = chars(M_XRES + M_HFRONT + M_HPULSE + M_HBACK) - H_TOT_BIAS;
   localparam int DEF_HDE  = chars(M_XRES) - LAST_BIAS;
   localparam int DEF_HSS  = chars(M_XRES + M_HFRONT);
   localparam int DEF_HSE  = chars(M_XRES + M_HFRONT + M_HPULSE);
   localparam int DEF_VTOT = M_YRES + M_VFRONT + M_VPULSE + M_VBACK - V_TOT_BIAS;
   localparam int DEF_VDE  = M_YRES - LAST_BIAS;
   localparam int DEF_VSS  = M_YRES + M_VFRONT - LAST_BIAS;
   localparam int DEF_VSE  = M_YRES + M_VFRONT + M_VPULSE - LAST_BIAS;
endpackage

// File: rtl/crt_axis_cnt.sv
module crt_axis_cnt #(
   parameter int CW   = 9,
   parameter int FW   = 8,
   parameter int BIAS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   input  logic [FW-1:0] tot_f,
   output logic [CW-1:0] cnt,
   output logic          last
);
   localparam int OFS = BIAS - 1;

   generate
      if (FW >= CW) begin : g_bad_width
         $error("counter must be wider than its total field");
      end
      if (BIAS < 1) begin : g_bad_bias
         $error("total bias must be at least one");
      end
   endgenerate

   logic [CW-1:0] last_val;
   assign last_val = CW'(tot_f) + CW'(OFS);
   assign last     = (cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (adv)    cnt <= last ? '0 : cnt + 1'b1;
   end

   // R2
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last) |=> (cnt == '0));
   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt));
   // R2
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last_val);
endmodule

// File: rtl/crt_sync_win.sv
module crt_sync_win #(
   parameter int CW         = 9,
   parameter int SW         = 8,
   parameter int EW         = 5,
   parameter int START_BIAS = 0,
   parameter int END_BIAS   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] cnt,
   input  logic [SW-1:0] start_f,
   input  logic [EW-1:0] end_f,
   output logic          sync
);
   generate
      if (EW > CW || SW >= CW) begin : g_bad_width
         $error("sync field wider than its counter");
      end
   endgenerate

   logic [CW-1:0] start_val;
   logic [EW-1:0] end_val;
   logic          start_hit, end_hit, act;

   assign start_val = CW'(start_f) + CW'(START_BIAS);

   generate
      if (END_BIAS == 0) begin : g_end_raw
         assign end_val = end_f;
      end else begin : g_end_bias
         assign end_val = end_f + EW'(END_BIAS);
      end
   endgenerate

   assign start_hit = (cnt == start_val);
   assign end_hit   = (cnt[EW-1:0] == end_val);
   assign sync      = start_hit | (act & ~end_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     act <= 1'b0;
      else if (clr)   act <= 1'b0;
      else if (step)  act <= sync;
   end

   // R5
   rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync) |-> (cnt == start_val));
   // R9
   fall_on_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sync) && !$past(clr)) |-> (cnt[EW-1:0] == end_val));
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
   import crt_tg_pkg::*;
#(
   parameter int HF_W     = 8,
   parameter int VF_W     = 12,
   parameter int HSE_W    = 5,
   parameter int VSE_W    = 4,
   parameter int RST_HTOT = DEF_HTOT,
   parameter int RST_HDE  = DEF_HDE,
   parameter int RST_HSS  = DEF_HSS,
   parameter int RST_HSE  = DEF_HSE,
   parameter int RST_VTOT = DEF_VTOT,
   parameter int RST_VDE  = DEF_VDE,
   parameter int RST_VSS  = DEF_VSS,
   parameter int RST_VSE  = DEF_VSE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [HF_W-1:0]  cfg_htot,
   input  logic [HF_W-1:0]  cfg_hde,
   input  logic [HF_W-1:0]  cfg_hss,
   input  logic [HSE_W-1:0] cfg_hse,
   input  logic [VF_W-1:0]  cfg_vtot,
   input  logic [VF_W-1:0]  cfg_vde,
   input  logic [VF_W-1:0]  cfg_vss,
   input  logic [VSE_W-1:0] cfg_vse,
   output logic [HF_W:0]    h_count,
   output logic [VF_W:0]    v_count,
   output logic             hsync,
   output logic             vsync,
   output logic             disp_en,
   output logic             frame_start
);
   localparam int HC_W = HF_W + 1;
   localparam int VC_W = VF_W + 1;

   generate
      if (RST_HTOT >= (1 << HF_W) || RST_VTOT >= (1 << VF_W)) begin : g_bad_rst
         $error("reset totals do not fit their fields");
      end
   endgenerate

   logic [HF_W-1:0]  htot_q, hde_q, hss_q;
   logic [HSE_W-1:0] hse_q;
   logic [VF_W-1:0]  vtot_q, vde_q, vss_q;
   logic [VSE_W-1:0] vse_q;
   logic             h_last, v_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         htot_q <= HF_W'(RST_HTOT);
         hde_q  <= HF_W'(RST_HDE);
         hss_q  <= HF_W'(RST_HSS);
         hse_q  <= HSE_W'(RST_HSE);
         vtot_q <= VF_W'(RST_VTOT);
         vde_q  <= VF_W'(RST_VDE);
         vss_q  <= VF_W'(RST_VSS);
         vse_q  <= VSE_W'(RST_VSE);
      end else if (cfg_load) begin
         htot_q <= cfg_htot;
         hde_q  <= cfg_hde;
         hss_q  <= cfg_hss;
         hse_q  <= cfg_hse;
         vtot_q <= cfg_vtot;
         vde_q  <= cfg_vde;
         vss_q  <= cfg_vss;
         vse_q  <= cfg_vse;
      end
   end

   crt_axis_cnt #(.CW(HC_W), .FW(HF_W), .BIAS(H_TOT_BIAS)) u_hcnt (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .adv(1'b1),
      .tot_f(htot_q), .cnt(h_count), .last(h_last));

   crt_axis_cnt #(.CW(VC_W), .FW(VF_W), .BIAS(V_TOT_BIAS)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .adv(h_last),
      .tot_f(vtot_q), .cnt(v_count), .last(v_last));

   crt_sync_win #(.CW(HC_W), .SW(HF_W), .EW(HSE_W),
                  .START_BIAS(0), .END_BIAS(0)) u_hsync (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .step(1'b1),
      .cnt(h_count), .start_f(hss_q), .end_f(hse_q), .sync(hsync));

   crt_sync_win #(.CW(VC_W), .SW(VF_W), .EW(VSE_W),
                  .START_BIAS(LAST_BIAS), .END_BIAS(LAST_BIAS)) u_vsync (
      .clk(clk), .rst_n(rst_n), .clr(cfg_load), .step(h_last),
      .cnt(v_count), .start_f(vss_q), .end_f(vse_q), .sync(vsync));

   assign disp_en     = (h_count <= HC_W'(hde_q)) && (v_count <= VC_W'(vde_q));
   assign frame_start = (h_count == '0) && (v_count == '0);

   // R8
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (h_count == '0 && v_count == '0));
   // R7
   sof_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   // R3
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_last && v_last && !cfg_load) |=> frame_start);
endmodule

// File: tb/crt_timing_gen_tb_top.sv
module crt_timing_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [7:0]  cfg_htot = '0, cfg_hde = '0, cfg_hss = '0;
   logic [4:0]  cfg_hse = '0;
   logic [11:0] cfg_vtot = '0, cfg_vde = '0, cfg_vss = '0;
   logic [3:0]  cfg_vse = '0;
   logic [8:0]  h_count;
   logic [12:0] v_count;
   logic        hsync, vsync, disp_en, frame_start;

   crt_timing_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_htot(cfg_htot), .cfg_hde(cfg_hde), .cfg_hss(cfg_hss), .cfg_hse(cfg_hse),
      .cfg_vtot(cfg_vtot), .cfg_vde(cfg_vde), .cfg_vss(cfg_vss), .cfg_vse(cfg_vse),
      .h_count(h_count), .v_count(v_count), .hsync(hsync), .vsync(vsync),
      .disp_en(disp_en), .frame_start(frame_start));

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_chk = 0;
   int    n_fail = 0;
   string hs_tag = "R5";
   string vs_tag = "R6";
   bit    done = 1'b0;

   // reference model state
   int m_htot, m_hde, m_hss, m_hse, m_vtot, m_vde, m_vss, m_vse;
   int hc, vc;
   bit hact, vact;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_defaults();
      // 640x480: characters 80 visible, 2 front, 12 sync, 6 back
      m_htot = (80 + 2 + 12 + 6) - 5;
      m_hde  = 80 - 1;
      m_hss  = 82;
      m_hse  = 94 % 32;
      m_vtot = (480 + 10 + 2 + 33) - 2;
      m_vde  = 480 - 1;
      m_vss  = 490 - 1;
      m_vse  = (492 - 1) % 16;
      hc = 0; vc = 0; hact = 0; vact = 0;
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         model_defaults();
      end else if (!done) begin
         bit e_hs, e_vs, e_de, e_sof;
         e_hs  = (hc == m_hss) || (hact && ((hc % 32) != m_hse));
         e_vs  = (vc == m_vss + 1) || (vact && ((vc % 16) != ((m_vse + 1) % 16)));
         e_de  = (hc <= m_hde) && (vc <= m_vde);
         e_sof = (hc == 0) && (vc == 0);
         chk(int'(h_count) == hc, "R2", "h_count", int'(h_count), hc);
         chk(int'(v_count) == vc, "R3", "v_count", int'(v_count), vc);
         chk(disp_en == e_de, "R4", "disp_en", int'(disp_en), int'(e_de));
         chk(hsync == e_hs, hs_tag, "hsync", int'(hsync), int'(e_hs));
         chk(vsync == e_vs, vs_tag, "vsync", int'(vsync), int'(e_vs));
         chk(frame_start == e_sof, "R7", "frame_start", int'(frame_start), int'(e_sof));
         if (cfg_load) begin
            m_htot = int'(cfg_htot); m_hde = int'(cfg_hde);
            m_hss  = int'(cfg_hss);  m_hse = int'(cfg_hse);
            m_vtot = int'(cfg_vtot); m_vde = int'(cfg_vde);
            m_vss  = int'(cfg_vss);  m_vse = int'(cfg_vse);
            hc = 0; vc = 0; hact = 0; vact = 0;
         end else begin
            hact = e_hs;
            if (hc == m_htot + 4) begin
               hc = 0;
               vact = e_vs;
               vc = (vc == m_vtot + 1) ? 0 : vc + 1;
            end else begin
               hc = hc + 1;
            end
         end
      end
   end

   task automatic load_cfg(input int ht, input int hd, input int hs, input int he,
                           input int vt, input int vd, input int vs, input int ve);
      @(posedge clk); #1;
      cfg_load = 1'b1;
      cfg_htot = 8'(ht); cfg_hde = 8'(hd); cfg_hss = 8'(hs); cfg_hse = 5'(he);
      cfg_vtot = 12'(vt); cfg_vde = 12'(vd); cfg_vss = 12'(vs); cfg_vse = 4'(ve);
      @(posedge clk); #1;
      cfg_load = 1'b0;
      cfg_htot = '0; cfg_hde = '0; cfg_hss = '0; cfg_hse = '0;
      cfg_vtot = '0; cfg_vde = '0; cfg_vss = '0; cfg_vse = '0;
      @(negedge clk);
      // R8: raster restarted after the load cycle
      chk(h_count == '0 && v_count == '0, "R8", "counters after load",
          int'(h_count) + int'(v_count), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(h_count == '0, "R1", "h_count in reset", int'(h_count), 0);
      chk(v_count == '0, "R1", "v_count in reset", int'(v_count), 0);
      chk(frame_start == 1'b1, "R1", "frame_start in reset", int'(frame_start), 1);
      chk(hsync == 1'b0 && vsync == 1'b0, "R1", "syncs in reset",
          int'(hsync) + int'(vsync), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      // R1: one full default frame (100 chars x 525 lines) plus a margin
      repeat (52600) @(posedge clk);
      // small mode: 20 chars, 10 lines, hsync 12..15, vsync lines 7..8
      load_cfg(15, 9, 12, 16, 8, 5, 6, 8);
      repeat (620) @(posedge clk);
      // R9: truncated ends, hsync 5..36, vsync lines 10..16
      hs_tag = "R9";
      vs_tag = "R9";
      load_cfg(60, 39, 5, 5, 20, 15, 9, 0);
      repeat (4400) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule